// File: doc/BRIEF.md
# Oversampling Serial Receiver with Flagged Receive Queue

This block turns an asynchronous serial line into a queue of received characters. The line is resynchronised and sampled sixteen times per bit period. A frame engine validates the start bit, gathers five to eight data bits least significant first, checks an optional parity bit and inspects the stop bit. Each finished character is stored in a sixteen-deep queue. The stored word carries the character together with its break, parity and framing flags and a valid marker.

Software configures the block through a control word and a divisor word, and removes characters by pulsing a pop strobe. Three interrupt conditions are kept as raw status: the queue overflowed, the queue fill passed a programmable level, and characters have waited unread for a programmable number of character times. Each condition has its own mask bit, and the masked conditions are combined into one interrupt line. A separate output reports that the queue holds data.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset, `rd_data`, `irq_raw`, `irq` and `rx_not_empty` are all zero, and the divisor and control settings are zero.
- R2: The sample tick period is `div+1` clocks, and one bit lasts 16 ticks. Data bits arrive least significant first. The control field `ctl[1:0]` = 0, 1, 2 or 3 selects 5, 6, 7 or 8 data bits. A popped word has the character in bits [7:0], zero-extended above the selected size, and bit 11 set as the valid marker.
- R3: `ctl[2]` enables a parity bit after the data bits. `ctl[3]` = 1 selects odd parity and 0 selects even parity. A received parity bit that does not match sets bit 9 of the stored word.
- R4: A stop bit sampled low sets bit 10 of the stored word. After such a frame, no new start bit is accepted until the line has been seen high.
- R5: When the data bits, the parity bit (if enabled) and the stop bit are all sampled low, bit 8 (break) is set. A low line held for several bit times produces exactly one entry.
- R6: The queue holds 16 entries and returns them in arrival order. A pop on an empty queue returns an all-zero word. `rx_not_empty` is high whenever entries are held.
- R7: A character that completes while the queue is full is discarded and sets `irq_raw[0]`. That bit stays set through pops and clears only when the control word is written with `ctl[6]` = 1. That write also empties the queue.
- R8: `irq_raw[1]` is high while the number of stored entries is strictly greater than the threshold field `ctl[18:11]`.
- R9: `irq_raw[2]` sets when the queue is non-empty and no push or pop has happened for `ctl[10:7]` character times. One character time is the frame length in bits times 16 ticks. Every push or pop restarts the count, and a count of zero disables the condition.
- R10: Characters are received only while both the receive enable `ctl[4]` and the tick-generator enable `ctl[5]` are 1. With either one at 0, a complete frame on the line leaves the queue empty.
- R11: `irq` is the OR of `irq_raw` ANDed bitwise with the mask field `ctl[21:19]`. Mask bit 19 gates `irq_raw[0]`, bit 20 gates `irq_raw[1]` and bit 21 gates `irq_raw[2]`.
- R12: A start bit is accepted only if the line is still low 8 ticks after the falling edge is seen. A low pulse shorter than half a bit leaves the queue empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Asynchronous serial line, idle high |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 22 | Control word: size, parity, enables, queue reset, timeout count, threshold, masks |
| div_we | input | 1 | Write strobe for the divisor word |
| div_wdata | input | DIV_W | Divisor: sample-tick period minus one, in clocks |
| pop | input | 1 | Removes the oldest entry; its word appears on `rd_data` one cycle later |
| rd_data | output | 12 | Popped word: valid, framing, parity, break flags and character |
| irq_raw | output | 3 | Raw status: overflow, above threshold, timeout |
| rx_not_empty | output | 1 | Queue holds at least one entry |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions assume that the line changes only on whole bit periods of the programmed divisor. They also assume that the control and divisor words are rewritten only while the frame engine is idle, so that no character straddles a change of size, parity or rate. The bench meets these assumptions. It builds every frame from whole bit periods derived from the divisor it last wrote. It writes new settings only after the trailing idle bit of the previous frame. It keeps divisors small, so each random character uses a fresh size, parity mode and rate without long runs.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;
  // Stored word, most significant field first: valid, framing, parity, break, character
  typedef struct packed {
    logic       valid;
    logic       frame_err;
    logic       par_err;
    logic       brk;
    logic [7:0] data;
  } rx_entry_t;

  localparam int ENT_W = $bits(rx_entry_t);

  typedef enum logic [2:0] {
    FR_IDLE, FR_START, FR_DATA, FR_PAR, FR_STOP, FR_HOLD
  } frame_state_t;

  localparam int IRQ_OVF = 0;
  localparam int IRQ_THR = 1;
  localparam int IRQ_TMO = 2;
  localparam int IRQ_N   = 3;
endpackage

// File: rtl/srx_tick.sv
`timescale 1ns/1ps
module srx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/srx_frame.sv
`timescale 1ns/1ps
module srx_frame
  import srx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] size,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       ent_push,
  output rx_entry_t  ent
);
  frame_state_t st;
  logic [3:0]   os;
  logic [2:0]   bit_idx;
  logic [7:0]   sh;
  logic         par_acc;
  logic         par_bit;
  logic [2:0]   last_idx;

  assign last_idx = 3'(size) + 3'd4;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st       <= FR_IDLE;
      os       <= '0;
      bit_idx  <= '0;
      sh       <= '0;
      par_acc  <= 1'b0;
      par_bit  <= 1'b0;
      ent_push <= 1'b0;
      ent      <= '0;
    end else begin
      ent_push <= 1'b0;
      if (tick) begin
        unique case (st)
          FR_IDLE: if (!rxd) begin
            st <= FR_START;
            os <= '0;
          end
          FR_START: begin
            if (os == 4'd7) begin
              os <= '0;
              if (!rxd) begin
                st      <= FR_DATA;
                bit_idx <= '0;
                sh      <= '0;
                par_acc <= 1'b0;
              end else begin
                st <= FR_IDLE;   // glitch rejected (R12)
              end
            end else begin
              os <= os + 1'b1;
            end
          end
          FR_DATA: begin
            if (os == 4'd15) begin
              os          <= '0;
              sh[bit_idx] <= rxd;
              par_acc     <= par_acc ^ rxd;
              if (bit_idx == last_idx) st <= par_en ? FR_PAR : FR_STOP;
              else bit_idx <= bit_idx + 1'b1;
            end else begin
              os <= os + 1'b1;
            end
          end
          FR_PAR: begin
            if (os == 4'd15) begin
              os      <= '0;
              par_bit <= rxd;
              st      <= FR_STOP;
            end else begin
              os <= os + 1'b1;
            end
          end
          FR_STOP: begin
            if (os == 4'd15) begin
              os            <= '0;
              ent_push      <= 1'b1;
              ent.valid     <= 1'b1;
              ent.data      <= sh;
              ent.frame_err <= !rxd;
              ent.par_err   <= par_en && (par_bit != (par_acc ^ par_odd));
              ent.brk       <= !rxd && (sh == 8'd0) && (!par_en || !par_bit);
              st            <= rxd ? FR_IDLE : FR_HOLD;
            end else begin
              os <= os + 1'b1;
            end
          end
          FR_HOLD: if (rxd) st <= FR_IDLE;   // wait for line release (R4, R5)
          default: st <= FR_IDLE;
        endcase
      end
    end
  end

  // R10: a character only completes while reception was enabled
  assert_push_needs_enable_R10: assert property (@(posedge clk) disable iff (rst)
    ent_push |-> $past(en));

  // R2: every completed character is marked valid
  assert_push_marked_valid_R2: assert property (@(posedge clk) disable iff (rst)
    ent_push |-> ent.valid);
endmodule

// File: rtl/srx_queue.sv
`timescale 1ns/1ps
module srx_queue #(
  parameter int DEPTH = 16,
  parameter int W     = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic [$clog2(DEPTH):0] level,
  output logic             full,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          do_push;
  logic          do_pop;

  assign full    = (level == (AW+1)'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) rdata <= '0;
    else if (pop)   rdata <= empty ? '0 : mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      level <= level + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  // R7: a push into a full queue is dropped
  assert_full_push_dropped_R7: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clr) |=> full);

  // R6: popping an empty queue leaves it empty
  assert_empty_pop_harmless_R6: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push && !clr) |=> empty);
endmodule

// File: rtl/serial_rx_unit.sv
`timescale 1ns/1ps
module serial_rx_unit #(
  parameter int DIV_W = 16,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxd,
  input  logic             ctl_we,
  input  logic [21:0]      ctl_wdata,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             pop,
  output logic [11:0]      rd_data,
  output logic [2:0]       irq_raw,
  output logic             rx_not_empty,
  output logic             irq
);
  import srx_pkg::*;

  localparam int LVL_W = $clog2(DEPTH) + 1;

  // control fields
  logic [1:0]       size_q;
  logic             par_en_q, par_odd_q, rx_en_q, brg_en_q;
  logic [3:0]       tmo_cfg_q;
  logic [7:0]       thr_q;
  logic [IRQ_N-1:0] mask_q;
  logic [DIV_W-1:0] div_q;
  logic             fifo_clr;

  assign fifo_clr = ctl_we && ctl_wdata[6];

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= '0; par_en_q <= 1'b0; par_odd_q <= 1'b0;
      rx_en_q <= 1'b0; brg_en_q <= 1'b0;
      tmo_cfg_q <= '0; thr_q <= '0; mask_q <= '0; div_q <= '0;
    end else begin
      if (ctl_we) begin
        size_q    <= ctl_wdata[1:0];
        par_en_q  <= ctl_wdata[2];
        par_odd_q <= ctl_wdata[3];
        rx_en_q   <= ctl_wdata[4];
        brg_en_q  <= ctl_wdata[5];
        tmo_cfg_q <= ctl_wdata[10:7];
        thr_q     <= ctl_wdata[18:11];
        mask_q    <= ctl_wdata[21:19];
      end
      if (div_we) div_q <= div_wdata;
    end
  end

  // line resynchronisation
  logic rxd_m, rxd_s;
  always_ff @(posedge clk) begin
    if (rst) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      rxd_m <= rxd;
      rxd_s <= rxd_m;
    end
  end

  logic tick;
  srx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .en(brg_en_q), .div(div_q), .tick(tick)
  );

  logic      frm_push;
  rx_entry_t frm_ent;
  srx_frame u_frame (
    .clk(clk), .rst(rst), .en(rx_en_q && brg_en_q), .tick(tick), .rxd(rxd_s),
    .size(size_q), .par_en(par_en_q), .par_odd(par_odd_q),
    .ent_push(frm_push), .ent(frm_ent)
  );

  logic [LVL_W-1:0] fifo_level;
  logic             fifo_full, fifo_empty;
  logic [ENT_W-1:0] fifo_rdata;
  srx_queue #(.DEPTH(DEPTH), .W(ENT_W)) u_queue (
    .clk(clk), .rst(rst), .clr(fifo_clr), .push(frm_push), .wdata(frm_ent),
    .pop(pop), .rdata(fifo_rdata), .level(fifo_level),
    .full(fifo_full), .empty(fifo_empty)
  );

  assign rd_data = fifo_rdata;

  // sticky overflow
  logic ovf_q;
  always_ff @(posedge clk) begin
    if (rst || fifo_clr)           ovf_q <= 1'b0;
    else if (frm_push && fifo_full) ovf_q <= 1'b1;
  end

  // character-time timeout
  logic       pop_ev;
  logic [3:0] os_t, bit_t, chr_t;
  logic [3:0] frame_bits;
  logic       tmo_hit;

  assign pop_ev     = pop && !fifo_empty;
  assign frame_bits = 4'd7 + 4'(size_q) + 4'(par_en_q);

  always_ff @(posedge clk) begin
    if (rst || fifo_clr || frm_push || pop_ev) begin
      os_t <= '0; bit_t <= '0; chr_t <= '0; tmo_hit <= 1'b0;
    end else if (tick && !fifo_empty && (tmo_cfg_q != 4'd0) && !tmo_hit) begin
      if (os_t == 4'd15) begin
        os_t <= '0;
        if (bit_t == frame_bits - 4'd1) begin
          bit_t <= '0;
          if (chr_t == tmo_cfg_q - 4'd1) tmo_hit <= 1'b1;
          else chr_t <= chr_t + 1'b1;
        end else begin
          bit_t <= bit_t + 1'b1;
        end
      end else begin
        os_t <= os_t + 1'b1;
      end
    end
  end

  // registered status outputs
  logic [IRQ_N-1:0] raw_n;
  always_comb begin
    raw_n          = '0;
    raw_n[IRQ_OVF] = ovf_q;
    raw_n[IRQ_THR] = 9'(fifo_level) > 9'(thr_q);
    raw_n[IRQ_TMO] = tmo_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_raw      <= '0;
      irq          <= 1'b0;
      rx_not_empty <= 1'b0;
    end else begin
      irq_raw      <= raw_n;
      irq          <= |(raw_n & mask_q);
      rx_not_empty <= !fifo_empty;
    end
  end

  // R7: overflow holds until a queue reset
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !fifo_clr) |=> ovf_q);

  // R9: timeout is only ever pending on a non-empty queue
  assert_tmo_needs_data_R9: assert property (@(posedge clk) disable iff (rst)
    tmo_hit |-> !fifo_empty);
endmodule

// File: tb/serial_rx_unit_test.sv
`timescale 1ns/1ps
module serial_rx_unit_test;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rxd = 1'b1;
  logic          ctl_we = 1'b0;
  logic [21:0]   ctl_wdata = '0;
  logic          div_we = 1'b0;
  logic [DW-1:0] div_wdata = '0;
  logic          pop = 1'b0;
  logic [11:0]   rd_data;
  logic [2:0]    irq_raw;
  logic          rx_not_empty;
  logic          irq;

  int checks = 0;
  int errors = 0;
  int cur_div = 0;

  always #2.5 clk = ~clk;

  serial_rx_unit #(.DIV_W(DW), .DEPTH(16)) uut (
    .clk(clk), .rst(rst), .rxd(rxd),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .div_we(div_we), .div_wdata(div_wdata),
    .pop(pop), .rd_data(rd_data), .irq_raw(irq_raw),
    .rx_not_empty(rx_not_empty), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_ctl(input int sz, input int pe, input int po, input int rxe,
                         input int brge, input int frst, input int tmo, input int thr,
                         input int msk);
    @(negedge clk);
    ctl_wdata = {3'(msk), 8'(thr), 4'(tmo), 1'(frst), 1'(brge), 1'(rxe),
                 1'(po), 1'(pe), 2'(sz)};
    ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic set_div(input int d);
    @(negedge clk);
    div_wdata = DW'(d);
    div_we = 1'b1;
    @(negedge clk);
    div_we = 1'b0;
    cur_div = d;
  endtask

  function automatic logic par_of(input logic [7:0] d, input int po, input int badp);
    return (^d) ^ po[0] ^ badp[0];
  endfunction

  // expected stored word: {valid, framing, parity, break, data}
  function automatic logic [11:0] exp_entry(input logic [7:0] d, input int pe,
                                            input int po, input int badp, input int stop_hi);
    logic ferr, perr, brk, pbit;
    pbit = par_of(d, po, badp);
    ferr = (stop_hi == 0);
    perr = (pe != 0) && (badp != 0);
    brk  = ferr && (d == 8'd0) && ((pe == 0) || !pbit);
    return {1'b1, ferr, perr, brk, d};
  endfunction

  task automatic send_frame(input logic [7:0] d, input int nbits, input int pe,
                            input int po, input int badp, input int stop_hi,
                            input int extra_low);
    int bc;
    bc = 16 * (cur_div + 1);
    @(negedge clk);
    rxd = 1'b0;
    repeat (bc) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      rxd = d[i];
      repeat (bc) @(negedge clk);
    end
    if (pe != 0) begin
      rxd = par_of(d, po, badp);
      repeat (bc) @(negedge clk);
    end
    rxd = (stop_hi != 0);
    repeat (bc * (1 + extra_low)) @(negedge clk);
    rxd = 1'b1;
    repeat (bc) @(negedge clk);
  endtask

  task automatic pop_read(output logic [11:0] v);
    @(negedge clk);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    v = rd_data;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] v;
    logic [7:0]  vals [16];
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 rd_data", 32'(rd_data), 0);
    chk("R1 irq_raw", 32'(irq_raw), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rx_not_empty", 32'(rx_not_empty), 0);

    // R2 basic 8N1 character
    set_div(3);
    set_ctl(3, 0, 0, 1, 1, 0, 0, 15, 0);
    send_frame(8'hA5, 8, 0, 0, 0, 1, 0);
    chk("R6 not empty", 32'(rx_not_empty), 1);
    pop_read(v);
    chk("R2 8-bit char", 32'(v), 32'(exp_entry(8'hA5, 0, 0, 0, 1)));
    pop_read(v);
    chk("R6 empty pop", 32'(v), 0);

    // R3 directed bad parity, 7 data bits, even
    set_ctl(2, 1, 0, 1, 1, 0, 0, 15, 0);
    send_frame(8'h4B, 7, 1, 0, 1, 1, 0);
    pop_read(v);
    chk("R3 bad even parity", 32'(v), 32'(exp_entry(8'h4B, 1, 0, 1, 1)));

    // R4 directed framing error
    set_ctl(3, 0, 0, 1, 1, 0, 0, 15, 0);
    send_frame(8'h3C, 8, 0, 0, 0, 0, 0);
    pop_read(v);
    chk("R4 framing flag", 32'(v), 32'(exp_entry(8'h3C, 0, 0, 0, 0)));

    // random characters: size, parity, rate and errors vary
    for (int i = 0; i < 40; i++) begin
      int sz, nb, pe, po, badp, sth;
      logic [7:0] d;
      sz   = $urandom_range(0, 3);
      nb   = 5 + sz;
      pe   = $urandom_range(0, 1);
      po   = $urandom_range(0, 1);
      badp = ($urandom_range(0, 7) == 0) ? 1 : 0;
      sth  = ($urandom_range(0, 7) == 0) ? 0 : 1;
      d    = 8'($urandom) & 8'((1 << nb) - 1);
      if ($urandom_range(0, 9) == 0) d = 8'd0;
      set_div($urandom_range(0, 4));
      set_ctl(sz, pe, po, 1, 1, 0, 0, 15, 0);
      send_frame(d, nb, pe, po, badp, sth, 0);
      pop_read(v);
      chk("R2,R3,R4,R5 random char", 32'(v), 32'(exp_entry(d, pe, po, badp, sth)));
    end

    // R5 long break yields a single entry
    set_div(3);
    set_ctl(3, 0, 0, 1, 1, 0, 0, 15, 0);
    send_frame(8'h00, 8, 0, 0, 0, 0, 3);
    pop_read(v);
    chk("R5 break entry", 32'(v), 32'h D00);
    pop_read(v);
    chk("R5 single entry", 32'(v), 0);

    // R12 short low pulse rejected
    @(negedge clk);
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (160) @(negedge clk);
    chk("R12 glitch ignored", 32'(rx_not_empty), 0);

    // R10 enables
    set_ctl(3, 0, 0, 0, 1, 0, 0, 15, 0);
    send_frame(8'h81, 8, 0, 0, 0, 1, 0);
    chk("R10 rx enable off", 32'(rx_not_empty), 0);
    set_ctl(3, 0, 0, 1, 0, 0, 0, 15, 0);
    send_frame(8'h81, 8, 0, 0, 0, 1, 0);
    chk("R10 tick enable off", 32'(rx_not_empty), 0);

    // fill, threshold, overflow, masks
    set_div(0);
    set_ctl(3, 0, 0, 1, 1, 0, 0, 4, 3);
    for (int k = 0; k < 16; k++) begin
      vals[k] = 8'(k * 17 + 3);
      send_frame(vals[k], 8, 0, 0, 0, 1, 0);
      if (k == 3) chk("R8 level 4 not above", 32'(irq_raw[1]), 0);
      if (k == 4) begin
        chk("R8 level 5 above", 32'(irq_raw[1]), 1);
        chk("R11 thr masked in", 32'(irq), 1);
      end
    end
    chk("R7 full no overflow", 32'(irq_raw[0]), 0);
    send_frame(8'hEE, 8, 0, 0, 0, 1, 0);
    chk("R7 overflow set", 32'(irq_raw[0]), 1);
    for (int k = 0; k < 16; k++) begin
      pop_read(v);
      chk("R6 order", 32'(v), 32'(exp_entry(vals[k], 0, 0, 0, 1)));
    end
    pop_read(v);
    chk("R7 dropped char", 32'(v), 0);
    repeat (2) @(negedge clk);
    chk("R7 sticky after pops", 32'(irq_raw[0]), 1);
    chk("R8 drained", 32'(irq_raw[1]), 0);
    chk("R11 ovf masked in", 32'(irq), 1);
    set_ctl(3, 0, 0, 1, 1, 0, 0, 4, 0);
    repeat (2) @(negedge clk);
    chk("R11 masked out", 32'(irq), 0);
    chk("R11 raw unaffected", 32'(irq_raw[0]), 1);
    send_frame(8'h11, 8, 0, 0, 0, 1, 0);
    send_frame(8'h22, 8, 0, 0, 0, 1, 0);
    set_ctl(3, 0, 0, 1, 1, 1, 0, 4, 0);
    repeat (2) @(negedge clk);
    chk("R7 reset clears ovf", 32'(irq_raw[0]), 0);
    chk("R7 reset empties", 32'(rx_not_empty), 0);
    pop_read(v);
    chk("R7 reset pop empty", 32'(v), 0);

    // R9 timeout: one 10-bit character time at div 1 is 320 clocks
    set_div(1);
    set_ctl(3, 0, 0, 1, 1, 0, 1, 15, 4);
    send_frame(8'h55, 8, 0, 0, 0, 1, 0);
    chk("R9 not yet", 32'(irq_raw[2]), 0);
    repeat (200) @(negedge clk);
    chk("R9 still early", 32'(irq_raw[2]), 0);
    repeat (150) @(negedge clk);
    chk("R9 timeout set", 32'(irq_raw[2]), 1);
    chk("R11 timeout irq", 32'(irq), 1);
    pop_read(v);
    @(negedge clk);
    chk("R9 pop clears", 32'(irq_raw[2]), 0);
    repeat (400) @(negedge clk);
    chk("R9 empty stays clear", 32'(irq_raw[2]), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule